// File: doc/BRIEF.md
# Quad-Redundant Serial Stream Voter

This block protects one high-volume output channel that four redundant processor copies produce in lockstep. Each copy pushes parallel words into its own lane FIFO. The voter owns the single unload control. When that control is accepted, all four FIFOs release one word on the same clock edge into per-lane shift registers. The four streams therefore stay bit-aligned with no per-lane skew logic.

The four most significant bits are combined by a 4-input majority voter each cycle. The block emits one corrected serial stream, most significant bit first. A lone dissenting lane is outvoted and reported on a per-bit dissent mask. A two-against-two split cannot be corrected. It is flagged, and the bit falls back to a fixed lane. Per-lane saturating counters accumulate dissent events for telemetry.

Word input uses valid/ready per lane. `in_ready[i]` is high whenever lane i's FIFO has room. A word is taken on a cycle where valid and ready are both high. A valid word offered while ready is low is dropped, and the lane's sticky overflow flag is set. The serial output also uses valid/ready: `out_valid` marks a bit on `out_bit`, and `out_ready` acts as the shift enable. One bit is consumed per cycle in which both are high. While `out_ready` is low the bit holds.

Top module: `qmr_stream_voter`

## Requirements
- R1: Lane i's `in_ready[i]` is high exactly when its FIFO holds fewer than DEPTH words. A word offered with `in_valid[i]` and `in_ready[i]` both high is stored, and lane words leave in arrival order.
- R2: A word offered with `in_valid[i]` high while `in_ready[i]` is low is discarded. On the next cycle `ovf_flag[i]` reads 1 and stays 1 until reset.
- R3: A `start` pulse while no word is being shifted and all four FIFOs are non-empty pops one word from every lane on that edge. `out_valid` is high from the next cycle.
- R4: A `start` pulse while any FIFO is empty starts nothing, and `not_ready` reads 1 from the next cycle. It clears on the next accepted start. A `start` while a word is being shifted is ignored.
- R5: Bits leave most significant bit first, one per cycle with `out_valid` and `out_ready` both high. While `out_ready` is low, `out_valid` and `out_bit` hold. After WORD_W transfers `out_valid` falls.
- R6: When three or four lanes agree on the current bit, `out_bit` is the majority value. A single disagreeing lane i drives `dissent` to a mask with only bit i set, and `uncorr` is 0.
- R7: When lanes split two against two, `uncorr` is 1, `dissent` is 0, and `out_bit` equals lane 0's bit.
- R8: Lane i's counter, field `err_cnt[16*i +: 16]`, adds one per transferred bit on which lane i dissents. It stops at 65535.
- R9: `cnt_clr[i]` high for one cycle makes lane i's counter read 0 on the next cycle, even if the lane dissents in that cycle.
- R10: After reset all FIFOs are empty. `in_ready` is 4'hF, and `out_valid`, `not_ready`, `ovf_flag` and all counters are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 4 | Per-lane word valid |
| in_data | input | 4*WORD_W | Lane i word at bits [WORD_W*i +: WORD_W] |
| in_ready | output | 4 | Per-lane FIFO has room |
| ovf_flag | output | 4 | Sticky per-lane overflow |
| start | input | 1 | Unload request for all four lanes |
| not_ready | output | 1 | Last start refused because a FIFO was empty |
| out_valid | output | 1 | A voted bit is on out_bit |
| out_ready | input | 1 | Shift enable; bit consumed when high with out_valid |
| out_bit | output | 1 | Voted serial data, MSB first |
| dissent | output | 4 | Lane outvoted on current bit (valid with out_valid) |
| uncorr | output | 1 | Current bit is a 2-2 split |
| cnt_clr | input | 4 | Per-lane counter clear, write one to clear |
| err_cnt | output | 4*CNT_W | Lane i counter at bits [CNT_W*i +: CNT_W] |

## Verification
The bench offers a word to a lane whose FIFO is already full, then drains it. A design that kept the extra word, or that overwrote an older one, would shift out the wrong data. It also pulses start with one lane empty; a voter that unloaded anyway would misalign that lane by a word for the rest of the run. It forces two-against-two splits to catch a tie that picks the wrong lane or gets counted as a dissent. It drives one lane to dissent on every bit for more than 65535 bits and clears a counter in the same cycle as a dissent, which exposes a counter that wraps or lets the increment win.

// File: rtl/qsv_pkg.sv
package qsv_pkg;
  localparam int QSV_LANES = 4;

  typedef struct packed {
    logic       bit_o;
    logic [3:0] dissent;
    logic       split;
  } vote_t;
endpackage

// File: rtl/qsv_lane_fifo.sv
module qsv_lane_fifo #(
  parameter int WORD_W = 8,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_valid,
  input  logic [WORD_W-1:0] push_data,
  output logic              push_ready,
  input  logic              pop,
  output logic [WORD_W-1:0] pop_data,
  output logic              nonempty,
  output logic              ovf
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [WORD_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wr_ptr, rd_ptr;
  logic [CW-1:0]     level;
  logic              wr, rd;

  function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign push_ready = (level != CW'(DEPTH));
  assign nonempty   = (level != '0);
  assign wr         = push_valid && push_ready;
  assign rd         = pop && nonempty;
  assign pop_data   = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (wr) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
      ovf    <= 1'b0;
    end else begin
      if (wr) wr_ptr <= ptr_next(wr_ptr);
      if (rd) rd_ptr <= ptr_next(rd_ptr);
      level <= level + CW'(wr) - CW'(rd);
      if (push_valid && !push_ready) ovf <= 1'b1;
    end
  end

  // R1
  pop_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> nonempty);

  // R2
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> ovf);
endmodule

// File: rtl/qsv_vote4.sv
module qsv_vote4
  import qsv_pkg::*;
(
  input  logic [3:0] lane_bits,
  output vote_t      result
);
  logic [2:0] ones;

  always_comb begin
    ones = '0;
    for (int i = 0; i < 4; i++) ones = ones + {2'b00, lane_bits[i]};
    result.split = 1'b0;
    case (ones)
      3'd3, 3'd4: result.bit_o = 1'b1;
      3'd2: begin
        result.bit_o = lane_bits[0];
        result.split = 1'b1;
      end
      default: result.bit_o = 1'b0;
    endcase
    for (int i = 0; i < 4; i++)
      result.dissent[i] = ((ones == 3'd3) && !lane_bits[i]) ||
                          ((ones == 3'd1) && lane_bits[i]);
  end
endmodule

// File: rtl/qsv_dissent_counter.sv
module qsv_dissent_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             clr,
  output logic [CNT_W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (!rst_n)                cnt <= '0;
    else if (clr)              cnt <= '0;
    else if (inc && cnt != '1) cnt <= cnt + CNT_W'(1);
  end

  // R9
  clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt == '0));

  // R8
  sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '1 && !clr) |=> (cnt == '1));
endmodule

// File: rtl/qmr_stream_voter.sv
module qmr_stream_voter
  import qsv_pkg::*;
#(
  parameter int WORD_W = 8,
  parameter int DEPTH  = 4,
  parameter int CNT_W  = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [QSV_LANES-1:0]        in_valid,
  input  logic [QSV_LANES*WORD_W-1:0] in_data,
  output logic [QSV_LANES-1:0]        in_ready,
  output logic [QSV_LANES-1:0]        ovf_flag,
  input  logic                        start,
  output logic                        not_ready,
  output logic                        out_valid,
  input  logic                        out_ready,
  output logic                        out_bit,
  output logic [QSV_LANES-1:0]        dissent,
  output logic                        uncorr,
  input  logic [QSV_LANES-1:0]        cnt_clr,
  output logic [QSV_LANES*CNT_W-1:0]  err_cnt
);
  localparam int BW = $clog2(WORD_W + 1);

  logic [WORD_W-1:0]    pop_data [QSV_LANES];
  logic [WORD_W-1:0]    sh       [QSV_LANES];
  logic [QSV_LANES-1:0] nonempty;
  logic [QSV_LANES-1:0] msb;
  logic                 active;
  logic [BW-1:0]        bits_left;
  logic                 all_ne, go, xfer;
  vote_t                v;

  assign all_ne = &nonempty;
  assign go     = start && !active && all_ne;
  assign xfer   = active && out_ready;

  for (genvar g = 0; g < QSV_LANES; g++) begin : g_lane
    qsv_lane_fifo #(.WORD_W(WORD_W), .DEPTH(DEPTH)) fifo_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .push_valid (in_valid[g]),
      .push_data  (in_data[g*WORD_W +: WORD_W]),
      .push_ready (in_ready[g]),
      .pop        (go),
      .pop_data   (pop_data[g]),
      .nonempty   (nonempty[g]),
      .ovf        (ovf_flag[g])
    );

    always_ff @(posedge clk) begin
      if (!rst_n)    sh[g] <= '0;
      else if (go)   sh[g] <= pop_data[g];
      else if (xfer) sh[g] <= {sh[g][WORD_W-2:0], 1'b0};
    end

    assign msb[g] = sh[g][WORD_W-1];

    qsv_dissent_counter #(.CNT_W(CNT_W)) cnt_i (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (xfer && dissent[g]),
      .clr   (cnt_clr[g]),
      .cnt   (err_cnt[g*CNT_W +: CNT_W])
    );
  end

  qsv_vote4 vote_i (
    .lane_bits (msb),
    .result    (v)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active    <= 1'b0;
      bits_left <= '0;
      not_ready <= 1'b0;
    end else begin
      if (go) begin
        active    <= 1'b1;
        bits_left <= BW'(WORD_W);
        not_ready <= 1'b0;
      end else begin
        if (start && !active) not_ready <= 1'b1;
        if (xfer) begin
          bits_left <= bits_left - BW'(1);
          if (bits_left == BW'(1)) active <= 1'b0;
        end
      end
    end
  end

  assign out_valid = active;
  assign out_bit   = active ? v.bit_o : 1'b0;
  assign dissent   = active ? v.dissent : '0;
  assign uncorr    = active && v.split;

  // R3
  start_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !out_valid && all_ne) |=> out_valid);

  // R4
  refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !out_valid && !all_ne) |=> (!out_valid && not_ready));

  // R5
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_bit)));

  // R7
  split_no_dissent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    uncorr |-> (dissent == '0));

  // R6
  single_dissent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dissent));
endmodule

// File: tb/qmr_stream_voter_tb.sv
module qmr_stream_voter_tb_top;
  localparam int W = 8;
  localparam int D = 4;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [3:0]    in_valid = '0;
  logic [4*W-1:0] in_data = '0;
  logic [3:0]    in_ready, ovf_flag, dissent, cnt_clr = '0;
  logic          start = 1'b0, out_ready = 1'b0;
  logic          not_ready, out_valid, out_bit, uncorr;
  logic [4*CW-1:0] err_cnt;

  int total = 0, fails = 0;
  logic [W-1:0] q [4][$];
  logic [3:0]   ovf_m = '0;
  int           cnt_m [4];
  bit           nr_m = 1'b0;

  always #10 clk = ~clk;

  qmr_stream_voter #(.WORD_W(W), .DEPTH(D), .CNT_W(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .ovf_flag(ovf_flag), .start(start),
    .not_ready(not_ready), .out_valid(out_valid), .out_ready(out_ready),
    .out_bit(out_bit), .dissent(dissent), .uncorr(uncorr),
    .cnt_clr(cnt_clr), .err_cnt(err_cnt));

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [5:0] ref_vote(input logic [3:0] b);
    int n = 0;
    logic [3:0] dm = '0;
    for (int i = 0; i < 4; i++) n += int'(b[i]);
    if (n == 2) return {b[0], 1'b1, 4'b0000};
    for (int i = 0; i < 4; i++) dm[i] = (n >= 3) ? !b[i] : b[i];
    return {(n >= 3), 1'b0, dm};
  endfunction

  task automatic chk_counts(input string req);
    for (int l = 0; l < 4; l++)
      chk(err_cnt[l*CW +: CW] == CW'(cnt_m[l]), req, err_cnt[l*CW +: CW], cnt_m[l]);
  endtask

  // entered and left at a falling edge
  task automatic push(input logic [3:0] m, input logic [4*W-1:0] d);
    for (int l = 0; l < 4; l++)
      chk(in_ready[l] == (q[l].size() < D), "R1", in_ready[l], q[l].size() < D);
    in_valid = m;
    in_data  = d;
    for (int l = 0; l < 4; l++)
      if (m[l]) begin
        if (q[l].size() < D) q[l].push_back(d[l*W +: W]);
        else ovf_m[l] = 1'b1;
      end
    @(negedge clk);
    in_valid = '0;
    chk(ovf_flag == ovf_m, "R2", ovf_flag, ovf_m);
  endtask

  task automatic run_word(input int clr_lane, input int clr_bit, input bit stall);
    logic [W-1:0] w [4];
    bit go;
    int b;
    go = 1'b1;
    for (int l = 0; l < 4; l++) if (q[l].size() == 0) go = 1'b0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (!go) begin
      nr_m = 1'b1;
      chk(out_valid == 1'b0, "R4", out_valid, 0);
      chk(not_ready == 1'b1, "R4", not_ready, 1);
      return;
    end
    nr_m = 1'b0;
    for (int l = 0; l < 4; l++) w[l] = q[l].pop_front();
    chk(out_valid == 1'b1, "R3", out_valid, 1);
    chk(not_ready == 1'b0, "R4", not_ready, 0);
    b = 0;
    while (b < W) begin
      logic [3:0] bits;
      logic [5:0] e;
      bit rdy;
      for (int l = 0; l < 4; l++) bits[l] = w[l][W-1-b];
      e = ref_vote(bits);
      chk(out_valid == 1'b1, "R5", out_valid, 1);
      chk(out_bit == e[5], e[4] ? "R7" : "R6", out_bit, e[5]);
      chk(uncorr == e[4], "R7", uncorr, e[4]);
      chk(dissent == e[3:0], "R6", dissent, e[3:0]);
      rdy = stall ? ($urandom % 3 != 0) : 1'b1;
      out_ready = rdy;
      cnt_clr = (rdy && clr_lane >= 0 && b == clr_bit) ? 4'(1 << clr_lane) : 4'b0;
      @(negedge clk);
      if (rdy) begin
        for (int l = 0; l < 4; l++) begin
          if (cnt_clr[l]) cnt_m[l] = 0;
          else if (e[l] && cnt_m[l] < 65535) cnt_m[l]++;
        end
        b++;
      end
      cnt_clr = '0;
    end
    out_ready = 1'b0;
    chk(out_valid == 1'b0, "R5", out_valid, 0);
    chk_counts(clr_lane >= 0 ? "R9" : "R8");
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    total++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [W-1:0] base, x;
    int mode, a, c;
    void'($urandom(32'd2024));
    for (int l = 0; l < 4; l++) cnt_m[l] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk(in_ready == 4'hF, "R10", in_ready, 4'hF);
    chk(out_valid == 1'b0, "R10", out_valid, 0);
    chk(not_ready == 1'b0, "R10", not_ready, 0);
    chk(ovf_flag == 4'h0, "R10", ovf_flag, 0);
    chk(err_cnt == '0, "R10", err_cnt, 0);

    // R4 refusal with lane 3 empty, then accepted start
    push(4'b0111, {8'h00, 8'hA5, 8'hA5, 8'hA5});
    run_word(-1, 0, 0);
    chk(q[0].size() == 1, "R4", q[0].size(), 1);
    push(4'b1000, {8'hA5, 24'h0});
    run_word(-1, 0, 0);

    // R7 two-against-two split on every bit
    push(4'hF, {8'h0F, 8'h0F, 8'hF0, 8'hF0});
    run_word(-1, 0, 1);

    // R1/R2 fill all lanes, overflow lane 1, drain in order
    for (int k = 0; k < D; k++)
      push(4'hF, {4{8'(8'h11 * (k + 1))}});
    push(4'b0010, {8'h0, 8'h0, 8'hEE, 8'h0});
    for (int k = 0; k < D; k++) run_word(-1, 0, 1);
    run_word(-1, 0, 0);
    chk(ovf_flag == 4'b0010, "R2", ovf_flag, 4'b0010);

    // R9 clear wins over a dissent in the same cycle
    push(4'hF, {8'hC3, 8'h3C, 8'hC3, 8'hC3});
    run_word(2, 3, 0);
    cnt_clr = 4'b0001;
    @(negedge clk);
    cnt_clr = '0;
    cnt_m[0] = 0;
    chk_counts("R9");

    // random lanes: agreement, single dissent, pair flips, noise
    for (int n = 0; n < 60; n++) begin
      logic [4*W-1:0] d;
      base = W'($urandom);
      x    = W'($urandom);
      mode = $urandom % 4;
      a    = $urandom % 4;
      c    = (a + 1 + $urandom % 3) % 4;
      for (int l = 0; l < 4; l++) begin
        d[l*W +: W] = base;
        if (mode == 1 && l == a) d[l*W +: W] = base ^ x;
        if (mode == 2 && (l == a || l == c)) d[l*W +: W] = base ^ x;
        if (mode == 3) d[l*W +: W] = W'($urandom);
      end
      push(4'hF, d);
      run_word(-1, 0, 1);
    end

    // R8 saturation: lane 3 dissents on every bit
    cnt_clr = 4'hF;
    @(negedge clk);
    cnt_clr = '0;
    for (int l = 0; l < 4; l++) cnt_m[l] = 0;
    chk_counts("R9");
    for (int n = 0; n < 8200; n++) begin
      base = W'($urandom);
      push(4'hF, {~base, base, base, base});
      run_word(-1, 0, 0);
    end
    chk(err_cnt[3*CW +: CW] == 16'hFFFF, "R8", err_cnt[3*CW +: CW], 16'hFFFF);
    chk(err_cnt[0 +: CW] == 16'h0, "R8", err_cnt[0 +: CW], 0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule